// File: doc/BRIEF.md
# Majority-Vote Oversampling Serial Byte Receiver

This block takes an asynchronous serial input line and turns it into 8-bit bytes. Frames have one low start bit, eight data bits sent least significant bit first, and a high stop bit, with no parity. The line is first passed through a flop synchroniser. It is then examined at sixteen ticks per bit period. The tick rate comes from a programmable divisor: one tick every `div_i + 1` clock cycles, so one bit lasts `16 * (div_i + 1)` clock cycles.

Each bit is not decided by one sample in the middle. Three samples are taken at ticks 7, 8 and 9 of the bit window, counting the first tick after the bit's start as tick 1. The value that appears in two of the three samples wins. A start bit that does not survive this vote is treated as line noise. A frame whose stop bit votes low is thrown away. Good bytes go into an 8-entry first-in first-out queue. The oldest entry is always visible at the read port, and a pop strobe removes it.

The queue reports whether it is empty and how many entries it holds. It also raises a watermark flag whenever it holds more entries than a 3-bit threshold. A single enable gates reception as a whole.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset the queue is empty: `empty_o` = 1, `level_o` = 0 and `wm_o` = 0.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, each lasting `16*(div_i+1)` clock cycles. A complete frame adds exactly one entry holding the data byte.
- R3: Each bit takes the majority of three samples taken at bit ticks 7, 8 and 9. A disturbance covering one of those samples leaves the bit unchanged; a disturbance covering two of them flips it.
- R4: A falling edge starts a frame. If the start bit then votes high, the receiver returns to idle and pushes nothing. A following well-formed frame is received normally.
- R5: A frame whose stop bit votes low is discarded, and the queue is unchanged.
- R6: `rd_data_o` shows the oldest entry. A pop removes it, and entries leave in arrival order. A pop while the queue is empty has no effect.
- R7: A byte that completes while the queue holds 8 entries is dropped, and the stored entries stay intact.
- R8: `level_o` equals the number of stored entries, from 0 to 8. `empty_o` is 1 exactly when `level_o` is 0.
- R9: `wm_o` is 1 exactly when `level_o` is strictly greater than the 3-bit `wm_thresh_i`.
- R10: While `enable_i` is 0, no frame starts and nothing is pushed. Dropping `enable_i` in the middle of a frame abandons that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Receiver enable |
| div_i | input | 16 | Tick divisor; one tick every div_i+1 cycles |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| pop_i | input | 1 | Remove the oldest queue entry |
| wm_thresh_i | input | 3 | Watermark threshold |
| rd_data_o | output | 8 | Oldest queue entry |
| empty_o | output | 1 | Queue empty |
| level_o | output | 4 | Queue occupancy |
| wm_o | output | 1 | Occupancy above threshold |

## Verification
A received byte lands in the queue about 9.6 bit times after its start edge: the 2-cycle synchroniser, the edge detector, and then the decision at tick 9 of the stop bit. The bench therefore waits for two further idle bit times before it inspects `level_o` and `rd_data_o`. Line disturbances are placed in clock windows at least four cycles away from the sample instants, so a cycle of synchroniser skew cannot move a sample into or out of a window. A pop changes `level_o`, `empty_o` and `rd_data_o` at the next clock edge. The watermark flag follows `level_o` and `wm_thresh_i` combinationally, so the bench reads these at the falling edge after the event that changes them.

// File: rtl/uart_vote_pkg.sv
package uart_vote_pkg;

   // Oversampling ratio and tick counter width
   localparam int unsigned OVS   = 16;
   localparam int unsigned OVS_W = $clog2(OVS);
   // Centre tick of a bit window (ticks counted from 1)
   localparam int unsigned MID   = OVS / 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("uvr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= RESET_VAL;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= RESET_VAL;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uvr_tick.sv
module uvr_tick #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hold_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   if (DIV_W < 1) begin : g_bad_div
      $error("uvr_tick: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q == div_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (hold_i) cnt_q <= '0;
      else if (wrap)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = wrap & ~hold_i;

endmodule

// File: rtl/uvr_framer.sv
module uvr_framer
   import uart_vote_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned VOTES  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              line_i,
   input  logic              tick_i,
   output logic              hold_o,
   output logic              push_o,
   output logic [DATA_W-1:0] data_o
);

   if (VOTES != 1 && VOTES != 3) begin : g_bad_votes
      $error("uvr_framer: VOTES must be 1 or 3");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("uvr_framer: DATA_W must be at least 2");
   end

   localparam int unsigned BI_W = $clog2(DATA_W);
   localparam logic [OVS_W:0]  T_DECIDE = (OVS_W+1)'(MID + VOTES / 2);
   localparam logic [OVS_W:0]  T_END    = (OVS_W+1)'(OVS);
   localparam logic [BI_W-1:0] LAST_BIT = BI_W'(DATA_W - 1);

   rx_state_e          state_q;
   logic               prev_q;
   logic [OVS_W-1:0]   tick_q;
   logic [BI_W-1:0]    bit_q;
   logic [DATA_W-1:0]  shift_q;
   logic [OVS_W:0]     t_nxt;
   logic               busy;
   logic               bit_val;
   logic               at_decide;
   logic               at_end;

   assign busy      = (state_q != ST_IDLE);
   assign t_nxt     = {1'b0, tick_q} + 1'b1;
   assign at_decide = busy & tick_i & (t_nxt == T_DECIDE);
   assign at_end    = busy & tick_i & (t_nxt == T_END);

   // Bit decision variant
   if (VOTES == 3) begin : g_majority
      localparam logic [OVS_W:0] T_S0 = (OVS_W+1)'(MID - 1);
      localparam logic [OVS_W:0] T_S1 = (OVS_W+1)'(MID);
      logic [1:0] samp_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            samp_q <= '0;
         end else if (busy && tick_i) begin
            if (t_nxt == T_S0) samp_q[0] <= line_i;
            if (t_nxt == T_S1) samp_q[1] <= line_i;
         end
      end
      assign bit_val = (samp_q[0] & samp_q[1]) |
                       (samp_q[0] & line_i)    |
                       (samp_q[1] & line_i);
   end else begin : g_single
      assign bit_val = line_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         prev_q  <= 1'b1;
         tick_q  <= '0;
         bit_q   <= '0;
         shift_q <= '0;
      end else begin
         prev_q <= line_i;
         if (!busy) begin
            tick_q <= '0;
            bit_q  <= '0;
            if (en_i && prev_q && !line_i) state_q <= ST_START;
         end else if (!en_i) begin
            state_q <= ST_IDLE;
         end else if (tick_i) begin
            tick_q <= t_nxt[OVS_W-1:0];
            if (t_nxt == T_DECIDE) begin
               unique case (state_q)
                  ST_START: if (bit_val) state_q <= ST_IDLE;
                  ST_DATA:  shift_q <= {bit_val, shift_q[DATA_W-1:1]};
                  ST_STOP:  state_q <= ST_IDLE;
                  default:  state_q <= ST_IDLE;
               endcase
            end
            if (t_nxt == T_END) begin
               tick_q <= '0;
               unique case (state_q)
                  ST_START: begin
                     state_q <= ST_DATA;
                     bit_q   <= '0;
                  end
                  ST_DATA: begin
                     if (bit_q == LAST_BIT) state_q <= ST_STOP;
                     else                   bit_q   <= bit_q + 1'b1;
                  end
                  default: state_q <= ST_IDLE;
               endcase
            end
         end
      end
   end

   assign hold_o = ~busy;
   assign push_o = en_i & at_decide & (state_q == ST_STOP) & bit_val;
   assign data_o = shift_q;

   // at_end is consumed only through the same compare above; keep it observable
   logic unused_end;
   assign unused_end = at_end;

endmodule

// File: rtl/uvr_queue.sv
module uvr_queue #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned WIDTH = 8,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic [CNT_W-1:0] level_o,
   output logic             empty_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uvr_queue: DEPTH must be a power of two, at least 2");
   end
   if (CNT_W != $clog2(DEPTH + 1)) begin : g_bad_cnt
      $error("uvr_queue: CNT_W does not match DEPTH");
   end

   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wr_q, rd_q;
   logic [CNT_W-1:0] level_q;
   logic             empty_q;
   logic             push_ok, pop_ok;
   logic [CNT_W-1:0] level_d;

   assign push_ok = push_i & (level_q != FULL_LVL);
   assign pop_ok  = pop_i & ~empty_q;

   always_comb begin
      level_d = level_q;
      unique case ({push_ok, pop_ok})
         2'b10:   level_d = level_q + 1'b1;
         2'b01:   level_d = level_q - 1'b1;
         default: level_d = level_q;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (push_ok) mem_q[wr_q] <= data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_q    <= '0;
         rd_q    <= '0;
         level_q <= '0;
         empty_q <= 1'b1;
      end else begin
         if (push_ok) wr_q <= wr_q + 1'b1;
         if (pop_ok)  rd_q <= rd_q + 1'b1;
         level_q <= level_d;
         empty_q <= (level_d == '0);
      end
   end

   assign rd_data_o = mem_q[rd_q];
   assign level_o   = level_q;
   assign empty_o   = empty_q;

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
   import uart_vote_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned THR_W       = 3,
   parameter int unsigned VOTES       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              rx_i,
   input  logic              pop_i,
   input  logic [THR_W-1:0]  wm_thresh_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              empty_o,
   output logic [CNT_W-1:0]  level_o,
   output logic              wm_o
);

   if (THR_W >= CNT_W + 1) begin : g_bad_thr
      $error("uart_vote_rx: THR_W too wide for the queue depth");
   end

   logic              line_s;
   logic              tick;
   logic              hold;
   logic              push;
   logic [DATA_W-1:0] byte_w;
   logic [CNT_W-1:0]  level_w;

   uvr_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rx_i),
      .q_o   (line_s)
   );

   uvr_tick #(
      .DIV_W(DIV_W)
   ) u_tick (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .hold_i(hold),
      .div_i (div_i),
      .tick_o(tick)
   );

   uvr_framer #(
      .DATA_W(DATA_W),
      .VOTES (VOTES)
   ) u_framer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (enable_i),
      .line_i(line_s),
      .tick_i(tick),
      .hold_o(hold),
      .push_o(push),
      .data_o(byte_w)
   );

   uvr_queue #(
      .DEPTH(DEPTH),
      .WIDTH(DATA_W),
      .CNT_W(CNT_W)
   ) u_queue (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (push),
      .data_i   (byte_w),
      .pop_i    (pop_i),
      .rd_data_o(rd_data_o),
      .level_o  (level_w),
      .empty_o  (empty_o)
   );

   assign level_o = level_w;
   assign wm_o    = (level_w > CNT_W'(wm_thresh_i));

endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             enable_i,
   input logic             pop_i,
   input logic [CNT_W-1:0] level_o,
   input logic             empty_o
);

   // R8: occupancy never exceeds the queue depth
   assert_level_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(level_o) <= int'(DEPTH));

   // R8: empty flag agrees with occupancy
   assert_empty_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o == (level_o == '0));

   // R6: occupancy moves by at most one entry per cycle
   assert_level_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(level_o) <= int'($past(level_o)) + 1) &&
      (int'($past(level_o)) <= int'(level_o) + 1));

   // R6: a pop on an empty queue leaves it without going below zero
   assert_pop_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && empty_o) |=> (int'(level_o) <= 1));

   // R10: no entry is added while reception is disabled
   assert_disabled_no_push_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (level_o <= $past(level_o)));

   // R7: a full queue stays full until popped
   assert_full_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((int'(level_o) == int'(DEPTH)) && !pop_i) |=> (int'(level_o) == int'(DEPTH)));

endmodule

bind uart_vote_rx uart_vote_rx_chk #(
   .DEPTH(DEPTH),
   .CNT_W($clog2(DEPTH + 1))
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .enable_i(enable_i),
   .pop_i   (pop_i),
   .level_o (level_o),
   .empty_o (empty_o)
);

// File: tb/tb_uart_vote_rx.sv
`timescale 1ns/1ps
module tb_uart_vote_rx;

   localparam int DIVV = 7;
   localparam int P    = DIVV + 1;
   localparam int BITC = 16 * P;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b1;
   logic [15:0] div = 16'(DIVV);
   logic        rx = 1'b1;
   logic        pop = 1'b0;
   logic [2:0]  thr = 3'd0;
   logic [7:0]  rd;
   logic        empty;
   logic [3:0]  level;
   logic        wm;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_vote_rx dut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .div_i(div), .rx_i(rx),
      .pop_i(pop), .wm_thresh_i(thr), .rd_data_o(rd), .empty_o(empty),
      .level_o(level), .wm_o(wm)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // kind 0: clean, 1: flip one vote sample, 2: flip two vote samples
   task automatic send(input logic [7:0] d, input int gbit, input int kind,
                       input logic stop_v, input int abort_bit);
      for (int b = 0; b < 10; b++) begin
         for (int c = 0; c < BITC; c++) begin
            logic v;
            @(negedge clk);
            if (b == abort_bit && c == 0) en = 1'b0;
            v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
            if (b == gbit) begin
               if (kind == 1 && c >= 8*P - P/2 && c < 8*P + P/2) v = ~v;
               if (kind == 2 && c >= 7*P - P/2 && c < 8*P + P/2) v = ~v;
            end
            rx = v;
         end
      end
      @(negedge clk);
      rx = 1'b1;
      repeat (2*BITC) @(negedge clk);
      en = 1'b1;
   endtask

   task automatic do_pop();
      @(negedge clk) pop = 1'b1;
      @(negedge clk) pop = 1'b0;
   endtask

   task automatic sweep_wm(input string req, input int lvl);
      for (int t = 0; t < 8; t++) begin
         @(negedge clk) thr = 3'(t);
         #1 chk(req, int'(wm), (lvl > t) ? 1 : 0);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 empty", int'(empty), 1);
      chk("R1 level", int'(level), 0);
      chk("R1 wm", int'(wm), 0);

      // R2: clean frames of several patterns
      for (int i = 0; i < 6; i++) begin
         logic [7:0] d;
         d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 8'h4B + 8'h11);
         send(d, -1, 0, 1'b1, -1);
         chk("R2 level", int'(level), 1);
         chk("R2 data", int'(rd), int'(d));
         do_pop();
         chk("R6 empty after pop", int'(empty), 1);
      end

      // R3: one disturbed sample ignored, two flip the bit
      send(8'hA5, 4, 1, 1'b1, -1);
      chk("R3 single vote", int'(rd), 8'hA5);
      do_pop();
      send(8'hA5, 4, 2, 1'b1, -1);
      chk("R3 double vote", int'(rd), 8'hAD);
      do_pop();
      send(8'h3C, 9, 1, 1'b1, -1);
      chk("R3 stop single", int'(level), 1);
      do_pop();
      // R5: stop bit voted low by two samples
      send(8'h3C, 9, 2, 1'b1, -1);
      chk("R5 stop double", int'(level), 0);

      // R4: short start pulse rejected, then a normal frame
      @(negedge clk) rx = 1'b0;
      repeat (40) @(negedge clk);
      rx = 1'b1;
      repeat (2*BITC) @(negedge clk);
      chk("R4 glitch", int'(level), 0);
      send(8'h81, -1, 0, 1'b1, -1);
      chk("R4 recover", int'(rd), 8'h81);
      do_pop();

      // R5: stop bit fully low
      send(8'h55, -1, 0, 1'b0, -1);
      chk("R5 bad stop", int'(level), 0);

      // R6: pop on empty
      do_pop();
      chk("R6 pop empty level", int'(level), 0);
      chk("R6 pop empty flag", int'(empty), 1);

      // R10: disabled and aborted frames
      en = 1'b0;
      send(8'h42, -1, 0, 1'b1, 0);
      chk("R10 disabled", int'(level), 0);
      send(8'h42, -1, 0, 1'b1, 4);
      chk("R10 abort", int'(level), 0);
      send(8'h24, -1, 0, 1'b1, -1);
      chk("R10 re-enabled", int'(rd), 8'h24);
      do_pop();

      // R8/R9: fill with watermark sweep at every level
      sweep_wm("R9", 0);
      for (int k = 0; k < 8; k++) begin
         send(8'(k * 8'h29 + 8'h13), -1, 0, 1'b1, -1);
         chk("R8 level fill", int'(level), k + 1);
         chk("R8 empty fill", int'(empty), 0);
         sweep_wm("R9", k + 1);
      end
      // R7: ninth byte dropped
      send(8'hEE, -1, 0, 1'b1, -1);
      chk("R7 full level", int'(level), 8);
      // R6/R7: drain in order
      for (int k = 0; k < 8; k++) begin
         chk("R7 order", int'(rd), int'(8'(k * 8'h29 + 8'h13)));
         do_pop();
         chk("R8 level drain", int'(level), 7 - k);
         sweep_wm("R9", 7 - k);
      end
      chk("R8 empty end", int'(empty), 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule